// File: doc/BRIEF.md
# Multi-Line Transmit Character Silo

This block buffers outgoing characters for a group of serial lines. A single push port carries a character and a line number; the character lands in that line's private first-in first-out silo. Each silo offers its oldest character to the line's transmitter through a valid/ready handshake, but only while the line's transmit enable is high. Dropping the enable pauses the line between characters and keeps the queue intact.

Every line reports its current occupancy, so a nonzero count means output is still owed even on a paused line. A per-line flush throws the queue away. A line becomes busy when a character is accepted. It leaves the busy state when its silo drains to empty through the transmitter, or when a flush hits it. On that transition a per-line done flag is raised for the interrupt logic, and the flag holds until the host acknowledges it. A synchronous master clear returns every line to its empty, idle state.

Top module: `tx_silo_top`

## Requirements
- R1: Each silo holds up to DEPTH (default 32) characters, and `count_o` field *n* (bits [6n+5:6n] at defaults) gives line *n*'s occupancy one cycle after the push or pop that changes it.
- R2: A push with `push_valid_i` high is stored only in the silo selected by `push_line_i`; the counts of all other lines are unchanged.
- R3: While `tx_en_i[n]` is low, `tx_valid_o[n]` is low and no character leaves silo *n*. When the enable returns high, output continues with the next unsent character.
- R4: A pulse on `flush_i[n]` empties silo *n*, including a push to that line in the same cycle, and the count reads zero in the next cycle.
- R5: Characters leave each silo in push order, one per cycle in which `tx_valid_o[n]` and `tx_ready_i[n]` are both high. `tx_data_o` byte *n* (bits [8n+7:8n]) always shows the head character.
- R6: A line is busy from an accepted push until it completes. Completion is either the last character popping with no new push, or a flush while busy. Completion sets `done_o[n]`, which stays set until a `done_ack_i[n]` pulse clears it. If both happen in the same cycle, the set wins.
- R7: A push to a full silo is dropped and the count stays at DEPTH. It sets `overflow_o[n]`, which then stays set until master clear or reset.
- R8: A `clr_i` pulse, or a low `rst_ni`, empties all silos and clears every done flag, overflow bit and busy state.
- R9: A flush of a line that is not busy leaves its done flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous master clear |
| push_valid_i | input | 1 | Push a character this cycle |
| push_line_i | input | 3 | Target line of the push |
| push_data_i | input | 8 | Character to push |
| flush_i | input | 8 | Per-line flush pulse |
| tx_en_i | input | 8 | Per-line transmit enable |
| tx_ready_i | input | 8 | Per-line transmitter ready |
| done_ack_i | input | 8 | Per-line done acknowledge |
| tx_valid_o | output | 8 | Per-line character valid |
| tx_data_o | output | 64 | Per-line head character, 8 bits per line |
| count_o | output | 48 | Per-line occupancy, 6 bits per line |
| done_o | output | 8 | Per-line completion flag |
| overflow_o | output | 8 | Per-line sticky overflow |

## Verification
The bench builds the block with its default parameters: eight lines, each 32 deep, with 8-bit characters. At these values one line can be filled to exactly 32 and then pushed once more, which exercises the full boundary and the overflow path. The same run interleaves traffic across lines to show that a push reaches only its own silo. It also pauses a line partway through a drain to show that the line resumes from the correct character.

// File: rtl/tx_silo_pkg.sv
package tx_silo_pkg;
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned DEPTH     = 32;
  localparam int unsigned DATA_W    = 8;
  typedef logic [DATA_W-1:0] char_t;
endpackage

// File: rtl/tx_silo_fifo.sv
module tx_silo_fifo #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CW-1:0]     count_o,
  output logic              push_acc_o,
  output logic              pop_acc_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign push_acc_o = push_i && !full_o && !flush_i && !clr_i;
  assign pop_acc_o  = pop_i && (cnt_q != '0) && !flush_i && !clr_i;
  assign data_o     = mem_q[rd_q];
  assign count_o    = cnt_q;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else if (clr_i || flush_i) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else begin
      if (push_acc_o) wr_q <= inc(wr_q);
      if (pop_acc_o)  rd_q <= inc(rd_q);
      cnt_q <= cnt_q + CW'(push_acc_o) - CW'(pop_acc_o);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_acc_o) mem_q[wr_q] <= data_i;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0)); // R4
endmodule

// File: rtl/tx_silo_lane.sv
module tx_silo_lane #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              flush_i,
  input  logic              en_i,
  input  logic              ready_i,
  input  logic              ack_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CW-1:0]     count_o,
  output logic              done_o,
  output logic              overflow_o
);
  logic push_acc, pop_acc, full, busy_q, done_q, ovf_q, complete;

  assign valid_o = en_i && (count_o != '0) && !flush_i;

  tx_silo_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk_i, .rst_ni, .clr_i, .flush_i,
    .push_i, .data_i,
    .pop_i(valid_o && ready_i),
    .data_o, .count_o,
    .push_acc_o(push_acc), .pop_acc_o(pop_acc), .full_o(full)
  );

  // drained to empty, or flushed while owing output
  assign complete = busy_q && !clr_i &&
                    (flush_i || (pop_acc && count_o == CW'(1) && !push_acc));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; ovf_q <= 1'b0;
    end else if (clr_i) begin
      busy_q <= 1'b0; done_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      if (complete)      busy_q <= 1'b0;
      else if (push_acc) busy_q <= 1'b1;
      if (complete)      done_q <= 1'b1;
      else if (ack_i)    done_q <= 1'b0;
      if (push_i && full && !flush_i) ovf_q <= 1'b1;
    end
  end

  assign done_o     = done_q;
  assign overflow_o = ovf_q;

  AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !flush_i && !clr_i && !push_i) |=> (count_o == $past(count_o))); // R3
  AST_DONE_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_q)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clr_i) |=> overflow_o); // R7
  AST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_o && !overflow_o && !busy_q && count_o == '0)); // R8
  AST_IDLE_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !busy_q && !done_o) |=> !done_o); // R9
endmodule

// File: rtl/tx_silo_top.sv
module tx_silo_top
  import tx_silo_pkg::*;
#(
  parameter int unsigned N_LINES = NUM_LINES,
  parameter int unsigned SILO_D  = DEPTH,
  parameter int unsigned CHAR_W  = DATA_W,
  localparam int unsigned LW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int unsigned CW = $clog2(SILO_D + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  push_valid_i,
  input  logic [LW-1:0]         push_line_i,
  input  logic [CHAR_W-1:0]     push_data_i,
  input  logic [N_LINES-1:0]    flush_i,
  input  logic [N_LINES-1:0]    tx_en_i,
  input  logic [N_LINES-1:0]    tx_ready_i,
  input  logic [N_LINES-1:0]    done_ack_i,
  output logic [N_LINES-1:0]    tx_valid_o,
  output logic [N_LINES*CHAR_W-1:0] tx_data_o,
  output logic [N_LINES*CW-1:0] count_o,
  output logic [N_LINES-1:0]    done_o,
  output logic [N_LINES-1:0]    overflow_o
);
  logic [N_LINES-1:0] push_sel;

  always_comb begin
    push_sel = '0;
    if (push_valid_i) push_sel[push_line_i] = 1'b1;
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_lane
    tx_silo_lane #(.DEPTH(SILO_D), .DATA_W(CHAR_W)) u_lane (
      .clk_i, .rst_ni, .clr_i,
      .push_i    (push_sel[l]),
      .data_i    (push_data_i),
      .flush_i   (flush_i[l]),
      .en_i      (tx_en_i[l]),
      .ready_i   (tx_ready_i[l]),
      .ack_i     (done_ack_i[l]),
      .valid_o   (tx_valid_o[l]),
      .data_o    (tx_data_o[l*CHAR_W +: CHAR_W]),
      .count_o   (count_o[l*CW +: CW]),
      .done_o    (done_o[l]),
      .overflow_o(overflow_o[l])
    );
  end

  AST_ONE_PUSH_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_sel)); // R2
endmodule

// File: tb/tb_tx_silo_top.sv
module tb_tx_silo_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int D  = 32;
  localparam int CW = 6;

  logic clk = 0, rst_ni = 0, clr_i = 0, push_valid_i = 0;
  logic [2:0] push_line_i = 0;
  logic [7:0] push_data_i = 0;
  logic [NL-1:0] flush_i = 0, tx_en_i = 0, tx_ready_i = 0, done_ack_i = 0;
  logic [NL-1:0] tx_valid_o, done_o, overflow_o;
  logic [NL*8-1:0] tx_data_o;
  logic [NL*CW-1:0] count_o;

  int n_chk = 0, n_bad = 0;
  int exp_cnt [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_silo_top dut (.clk_i(clk), .rst_ni, .clr_i, .push_valid_i, .push_line_i,
    .push_data_i, .flush_i, .tx_en_i, .tx_ready_i, .done_ack_i,
    .tx_valid_o, .tx_data_o, .count_o, .done_o, .overflow_o);

  // line[10:8], data[7:0]
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 8'h11}, {3'd7, 8'h72}, {3'd3, 8'h33}, {3'd0, 8'h14},
    {3'd6, 8'h65}, {3'd3, 8'h36}, {3'd0, 8'h17}, {3'd4, 8'h48}};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input int l, input int d);
    push_valid_i = 1; push_line_i = 3'(l); push_data_i = 8'(d);
    step();
    push_valid_i = 0;
  endtask

  function automatic int cnt(input int l);
    return int'(count_o[l*CW +: CW]);
  endfunction
  function automatic int dat(input int l);
    return int'(tx_data_o[l*8 +: 8]);
  endfunction

  initial begin
    #(CLK_PERIOD*5000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) exp_cnt[l] = 0;
    #(CLK_PERIOD*2 + 1); rst_ni = 1; step();
    // R8 reset state
    check("R8 reset counts", int'(count_o), 0);
    check("R8 reset done", int'(done_o), 0);
    check("R8 reset ovf", int'(overflow_o), 0);

    // vector table: routing and counts, lines paused
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][10:8], VEC[i][7:0]);
      exp_cnt[VEC[i][10:8]]++;
      for (int l = 0; l < NL; l++) check("R2 routed count", cnt(l), exp_cnt[l]);
    end
    check("R3 paused no valid", int'(tx_valid_o), 0);
    check("R5 head line0", dat(0), 'h11);
    check("R5 head line3", dat(3), 'h33);
    check("R1 count pending while paused", cnt(0), 3);

    // drain line 0 in order
    tx_en_i[0] = 1; tx_ready_i[0] = 1; #1;
    begin
      int exp_d [3] = '{'h11, 'h14, 'h17};
      for (int i = 0; i < 3; i++) begin
        check("R5 valid", int'(tx_valid_o[0]), 1);
        check("R5 order", dat(0), exp_d[i]);
        step();
      end
    end
    check("R5 drained", cnt(0), 0);
    check("R6 done after drain", int'(done_o[0]), 1);
    check("R6 others idle", int'(done_o[7:1]), 0);
    done_ack_i[0] = 1; step(); done_ack_i[0] = 0;
    check("R6 ack clears", int'(done_o[0]), 0);

    // pause mid-drain on line 1
    tx_en_i[0] = 0; tx_ready_i[0] = 0;
    for (int i = 0; i < 4; i++) push(1, 'hA0 + i);
    tx_ready_i[1] = 1; tx_en_i[1] = 1; #1;
    check("R5 first", dat(1), 'hA0);
    step();
    tx_en_i[1] = 0;
    step(); step();
    check("R3 paused count", cnt(1), 3);
    check("R3 paused valid", int'(tx_valid_o[1]), 0);
    check("R3 paused head", dat(1), 'hA1);
    check("R6 no done while paused", int'(done_o[1]), 0);
    tx_en_i[1] = 1; #1;
    for (int i = 1; i < 4; i++) begin
      check("R3 resume order", dat(1), 'hA0 + i);
      step();
    end
    check("R6 done after resume", int'(done_o[1]), 1);
    tx_en_i[1] = 0; tx_ready_i[1] = 0;
    // R6 set wins over ack: push+drain last char while acking
    push(1, 'hB0);
    tx_en_i[1] = 1; tx_ready_i[1] = 1; done_ack_i[1] = 1; step();
    done_ack_i[1] = 0; tx_en_i[1] = 0;
    check("R6 set beats ack", int'(done_o[1]), 1);
    done_ack_i[1] = 1; step(); done_ack_i[1] = 0;

    // fill line 5 to full plus one
    for (int i = 0; i < D; i++) push(5, i);
    check("R1 full count", cnt(5), D);
    check("R7 no ovf at full", int'(overflow_o[5]), 0);
    push(5, 'hFF);
    check("R7 dropped", cnt(5), D);
    check("R7 ovf set", int'(overflow_o[5]), 1);
    check("R7 head intact", dat(5), 0);

    // flush line 5 with simultaneous push
    flush_i[5] = 1; push(5, 'h55); flush_i[5] = 0;
    check("R4 flushed", cnt(5), 0);
    check("R6 done on flush", int'(done_o[5]), 1);
    check("R7 ovf sticky", int'(overflow_o[5]), 1);
    done_ack_i[5] = 1; step(); done_ack_i[5] = 0;
    flush_i[5] = 1; step(); flush_i[5] = 0;
    check("R9 idle flush no done", int'(done_o[5]), 0);

    // master clear
    clr_i = 1; step(); clr_i = 0;
    check("R8 clr counts", int'(count_o), 0);
    check("R8 clr ovf", int'(overflow_o), 0);
    check("R8 clr done", int'(done_o), 0);
    // line drained by clear raises no done on next idle flush
    flush_i[3] = 1; step(); flush_i[3] = 0;
    check("R8 no busy after clr", int'(done_o[3]), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule